// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Interval Timer

This block sits beside an SPI shift engine and produces all of its timing from the system clock. For the serial clock it multiplies a small odd-or-two prescaler by a mostly power-of-two scaler to get a divide ratio. An optional double-rate bit halves that ratio. The block then runs a low phase and a high phase from the divided period, and reports each SCK transition as a one-cycle strobe.

The three chip-select intervals come from three independent interval counters. The first is the wait from chip-select assertion to the first SCK edge. The second is the wait from the last SCK edge to chip-select release. The third is the idle gap between frames. Each counter has its own prescale/scaler code pair. Each counter is started by a one-cycle pulse from the engine and answers with a one-cycle completion strobe. While any interval is counting, the serial clock is held in place. A stop pulse abandons every interval. The engine owns the chip-select pins, the shift register and the configuration storage; this block only measures time.

Top module: `spi_tmg_gen`

## Requirements
- R1: With `dbl_i` = 0, the SCK period (rise strobe to rise strobe) is P = Bp × Bs system clocks. Bp is taken from `baud_pre_i` as 0→2, 1→3, 2→5, 3→7. Bs is taken from `baud_scl_i` as 0→2, 1→4, 2→6, 3→8, and for codes 4 to 15 it is 2^code.
- R2: With `dbl_i` = 1, the SCK period is P = Bp × Bs / 2 system clocks.
- R3: The high phase (rise strobe to fall strobe) lasts floor(P/2) clocks and the low phase lasts P − floor(P/2). The duty cycle is therefore exactly 50% whenever P is even.
- R4: While `run_i` is low, `sck_o` is low and no SCK strobe is raised. The first cycle with `run_i` high counts as enabled cycle 1. The first rise strobe is raised in enabled cycle number equal to the low-phase length.
- R5: `sck_rise_o` and `sck_fall_o` are single-cycle strobes, never asserted together, and they alternate. `sck_o` is high from the edge that ends a rise strobe cycle and low from the edge that ends a fall strobe cycle.
- R6: `dly_start_i[0]` starts the lead interval (chip-select to first SCK). Its length is L = Dp × 2^(code+1) clocks, where Dp is taken from `lead_pre_i` as 0→1, 1→3, 2→5, 3→7 and code is `lead_scl_i`. If the start pulse is high in cycle k, `dly_done_o[0]` pulses only in cycle k+L.
- R7: `dly_start_i[1]` and `dly_done_o[1]` behave the same way for the trail interval (last SCK to chip-select release), using `trail_pre_i` and `trail_scl_i`.
- R8: `dly_start_i[2]` and `dly_done_o[2]` behave the same way for the inter-frame gap, using `gap_pre_i` and `gap_scl_i`.
- R9: While any interval counts (`dly_busy_o` high), no SCK strobe is raised and the SCK phase count is held. Counting resumes where it stopped, so the next edge is delayed by exactly the frozen cycles.
- R10: A `stop_i` pulse clears every running interval, and no completion strobe follows. When start and stop arrive in the same cycle, stop wins.
- R11: A start pulse to an interval that is already counting restarts it at its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_pre_i | input | 2 | SCK prescaler code |
| baud_scl_i | input | 4 | SCK scaler code |
| dbl_i | input | 1 | Double-rate select |
| lead_pre_i | input | 2 | Lead interval prescale code |
| lead_scl_i | input | 4 | Lead interval scaler code |
| trail_pre_i | input | 2 | Trail interval prescale code |
| trail_scl_i | input | 4 | Trail interval scaler code |
| gap_pre_i | input | 2 | Frame gap prescale code |
| gap_scl_i | input | 4 | Frame gap scaler code |
| run_i | input | 1 | Enable SCK generation; low parks SCK low |
| dly_start_i | input | 3 | Start pulses: bit 0 lead, bit 1 trail, bit 2 gap |
| stop_i | input | 1 | Abort all intervals |
| sck_o | output | 1 | Serial clock level |
| sck_rise_o | output | 1 | Rising-edge strobe |
| sck_fall_o | output | 1 | Falling-edge strobe |
| dly_done_o | output | 3 | Interval completion strobes, same bit order as starts |
| dly_busy_o | output | 1 | Any interval counting |

## Verification
The assertions assume that the code inputs stay stable while SCK runs or an interval counts. They also assume that the engine does not raise a start pulse in the cycle an interval completes. The stimulus respects both: codes are chosen at random from a fixed seed before each run and held for its full length, and restarts are placed strictly inside a running interval. Random code choices are kept small enough for the run to stay short. Directed cases add a large scaler, odd double-rate periods, a freeze in the middle of a phase, stop colliding with start, and restart.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;
  localparam int BPRE_W = 2;
  localparam int BSCL_W = 4;
  localparam int DPRE_W = 2;
  localparam int DSCL_W = 4;
  localparam int N_DLY  = 3;
  localparam int PER_W  = $clog2(7 * (1 << ((1 << BSCL_W) - 1)) + 1);
  localparam int DLY_W  = $clog2(7 * (1 << (1 << DSCL_W)) + 1);

  typedef enum logic [1:0] {
    DLY_LEAD  = 2'd0,
    DLY_TRAIL = 2'd1,
    DLY_GAP   = 2'd2
  } dly_sel_e;

  function automatic logic [3:0] baud_pre_f(input logic [BPRE_W-1:0] c);
    case (c)
      2'd0:    baud_pre_f = 4'd2;
      2'd1:    baud_pre_f = 4'd3;
      2'd2:    baud_pre_f = 4'd5;
      default: baud_pre_f = 4'd7;
    endcase
  endfunction

  function automatic logic [PER_W-1:0] baud_scl_f(input logic [BSCL_W-1:0] c);
    if (c < 4) baud_scl_f = PER_W'((32'(c) + 1) * 2);
    else       baud_scl_f = PER_W'(32'd1 << c);
  endfunction

  function automatic logic [DLY_W-1:0] dly_len_f(input logic [DPRE_W-1:0] p,
                                                 input logic [DSCL_W-1:0] s);
    logic [DLY_W-1:0] odd;
    odd = DLY_W'({p, 1'b1});
    dly_len_f = odd << (32'(s) + 1);
  endfunction
endpackage

// File: rtl/spi_tmg_baud_div.sv
module spi_tmg_baud_div
  import spi_tmg_pkg::*;
#(
  parameter int PW = PER_W
) (
  input  logic [BPRE_W-1:0] pre_i,
  input  logic [BSCL_W-1:0] scl_i,
  input  logic              dbl_i,
  output logic [PW-1:0]     hi_len_o,
  output logic [PW-1:0]     lo_len_o
);
  logic [PW-1:0] full, per;

  always_comb begin
    full     = PW'(baud_pre_f(pre_i)) * PW'(baud_scl_f(scl_i));
    per      = dbl_i ? (full >> 1) : full;
    hi_len_o = per >> 1;
    lo_len_o = per - hi_len_o;
  end
endmodule

// File: rtl/spi_tmg_sck_gen.sv
module spi_tmg_sck_gen #(
  parameter int PW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          hold_i,
  input  logic [PW-1:0] hi_len_i,
  input  logic [PW-1:0] lo_len_i,
  output logic          sck_o,
  output logic          rise_o,
  output logic          fall_o
);
  logic [PW-1:0] cnt_q, cur_len;
  logic          sck_q, en, hit;

  assign en      = run_i & ~hold_i;
  assign cur_len = sck_q ? hi_len_i : lo_len_i;
  // >= guards against a shortened period
  assign hit     = en && (cnt_q >= cur_len - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (en) begin
      if (hit) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt_q <= cnt_q + PW'(1);
      end
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = hit & ~sck_q;
  assign fall_o = hit & sck_q;
endmodule

// File: rtl/spi_tmg_dly_cnt.sv
module spi_tmg_dly_cnt
  import spi_tmg_pkg::*;
#(
  parameter int DW = DLY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DPRE_W-1:0] pre_i,
  input  logic [DSCL_W-1:0] scl_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [DW-1:0] cnt_q, len;
  logic          busy_q;

  assign len = DW'(dly_len_f(pre_i, scl_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (stop_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= len - DW'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - DW'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/spi_tmg_gen.sv
module spi_tmg_gen
  import spi_tmg_pkg::*;
#(
  parameter int PW = PER_W,
  parameter int DW = DLY_W,
  parameter int ND = N_DLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BPRE_W-1:0] baud_pre_i,
  input  logic [BSCL_W-1:0] baud_scl_i,
  input  logic              dbl_i,
  input  logic [DPRE_W-1:0] lead_pre_i,
  input  logic [DSCL_W-1:0] lead_scl_i,
  input  logic [DPRE_W-1:0] trail_pre_i,
  input  logic [DSCL_W-1:0] trail_scl_i,
  input  logic [DPRE_W-1:0] gap_pre_i,
  input  logic [DSCL_W-1:0] gap_scl_i,
  input  logic              run_i,
  input  logic [ND-1:0]     dly_start_i,
  input  logic              stop_i,
  output logic              sck_o,
  output logic              sck_rise_o,
  output logic              sck_fall_o,
  output logic [ND-1:0]     dly_done_o,
  output logic              dly_busy_o
);
  logic [PW-1:0]     hi_len, lo_len;
  logic [DPRE_W-1:0] pre_arr [ND];
  logic [DSCL_W-1:0] scl_arr [ND];
  logic [ND-1:0]     busy;

  always_comb begin
    for (int k = 0; k < ND; k++) begin
      pre_arr[k] = '0;
      scl_arr[k] = '0;
    end
    pre_arr[DLY_LEAD]  = lead_pre_i;
    scl_arr[DLY_LEAD]  = lead_scl_i;
    pre_arr[DLY_TRAIL] = trail_pre_i;
    scl_arr[DLY_TRAIL] = trail_scl_i;
    pre_arr[DLY_GAP]   = gap_pre_i;
    scl_arr[DLY_GAP]   = gap_scl_i;
  end

  spi_tmg_baud_div #(.PW(PW)) i_div (
    .pre_i    (baud_pre_i),
    .scl_i    (baud_scl_i),
    .dbl_i    (dbl_i),
    .hi_len_o (hi_len),
    .lo_len_o (lo_len)
  );

  for (genvar g = 0; g < ND; g++) begin : g_dly
    spi_tmg_dly_cnt #(.DW(DW)) i_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (dly_start_i[g]),
      .stop_i  (stop_i),
      .pre_i   (pre_arr[g]),
      .scl_i   (scl_arr[g]),
      .busy_o  (busy[g]),
      .done_o  (dly_done_o[g])
    );
  end

  assign dly_busy_o = |busy;

  spi_tmg_sck_gen #(.PW(PW)) i_sck (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .hold_i   (dly_busy_o),
    .hi_len_i (hi_len),
    .lo_len_i (lo_len),
    .sck_o    (sck_o),
    .rise_o   (sck_rise_o),
    .fall_o   (sck_fall_o)
  );
endmodule

// File: rtl/spi_tmg_gen_chk.sv
module spi_tmg_gen_chk #(
  parameter int ND = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          stop_i,
  input logic [ND-1:0] dly_start_i,
  input logic          sck_o,
  input logic          sck_rise_o,
  input logic          sck_fall_o,
  input logic [ND-1:0] dly_done_o,
  input logic          dly_busy_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_rise_o && sck_fall_o)); // R5
  AST_RISE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_o |=> sck_o); // R5
  AST_FALL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_fall_o |=> !sck_o); // R5
  AST_IDLE_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_o); // R4
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_busy_o |-> !(sck_rise_o || sck_fall_o)); // R9
  AST_STOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!dly_busy_o && dly_done_o == '0)); // R10
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_start_i != '0 && !stop_i) |=> dly_busy_o); // R11
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_done_o != '0) |-> dly_busy_o); // R6
  AST_DONE_PULSE_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_done_o[0] |=> !dly_done_o[0]); // R6
  AST_DONE_PULSE_TRAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_done_o[1] |=> !dly_done_o[1]); // R7
  AST_DONE_PULSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_done_o[2] |=> !dly_done_o[2]); // R8
endmodule

bind spi_tmg_gen spi_tmg_gen_chk #(.ND(ND)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .stop_i      (stop_i),
  .dly_start_i (dly_start_i),
  .sck_o       (sck_o),
  .sck_rise_o  (sck_rise_o),
  .sck_fall_o  (sck_fall_o),
  .dly_done_o  (dly_done_o),
  .dly_busy_o  (dly_busy_o)
);

// File: tb/test_spi_tmg_gen.sv
module test_spi_tmg_gen;
  localparam int CLK_T = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] baud_pre_i = '0;
  logic [3:0] baud_scl_i = '0;
  logic       dbl_i = 1'b0;
  logic [1:0] lead_pre_i = '0, trail_pre_i = '0, gap_pre_i = '0;
  logic [3:0] lead_scl_i = '0, trail_scl_i = '0, gap_scl_i = '0;
  logic       run_i = 1'b0;
  logic [2:0] dly_start_i = '0;
  logic       stop_i = 1'b0;
  logic       sck_o, sck_rise_o, sck_fall_o, dly_busy_o;
  logic [2:0] dly_done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_T/2) clk_i = ~clk_i;

  spi_tmg_gen i_spi_tmg_gen (
    .clk_i, .rst_ni, .baud_pre_i, .baud_scl_i, .dbl_i,
    .lead_pre_i, .lead_scl_i, .trail_pre_i, .trail_scl_i,
    .gap_pre_i, .gap_scl_i, .run_i, .dly_start_i, .stop_i,
    .sck_o, .sck_rise_o, .sck_fall_o, .dly_done_o, .dly_busy_o
  );

  function automatic int bpre(int c);
    case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction
  function automatic int bscl(int c);
    return (c < 4) ? 2 * (c + 1) : (1 << c);
  endfunction
  function automatic int dlen(int p, int s);
    return (2 * p + 1) * (2 << s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic run_sck(input int pc, input int sc, input bit db, input bit frz);
    int per, hi, lo, fl, r1, r2, f1, n, sck_after;
    string preq;
    per = (bpre(pc) * bscl(sc)) >> db;
    hi = per / 2;
    lo = per - hi;
    fl = frz ? dlen(0, 1) : 0;
    preq = db ? "R2" : "R1";
    baud_pre_i = 2'(pc); baud_scl_i = 4'(sc); dbl_i = db;
    lead_pre_i = 2'd0;   lead_scl_i = 4'd1;
    r1 = -1; r2 = -1; f1 = -1; sck_after = -1;
    n = lo + fl + per + 2;
    for (int i = 1; i <= n; i++) begin
      run_i = 1'b1;
      dly_start_i[0] = frz && (i == 1);
      @(negedge clk_i);
      if (sck_rise_o && sck_fall_o) chk(1'b0, "R5 strobes together", 1, 0);
      if (sck_rise_o) begin
        if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
      end
      if (sck_fall_o && f1 < 0) f1 = i;
      if (r1 > 0 && i == r1 + 1) sck_after = sck_o;
      step();
    end
    dly_start_i = '0;
    chk(r1 == lo + fl, frz ? "R9 frozen first rise" : "R4 first rise", r1, lo + fl);
    chk(f1 - r1 == hi, "R3 high phase", f1 - r1, hi);
    chk(r2 - r1 == per, preq, r2 - r1, per);
    chk(sck_after == 1, "R5 level after rise", sck_after, 1);
    run_i = 1'b0;
    step();
    @(negedge clk_i);
    chk(!sck_o && !sck_rise_o && !sck_fall_o, "R4 parked", int'(sck_o), 0);
    step();
  endtask

  // re_at > 1: restart cycle; stop_at > 0: stop cycle
  task automatic run_dly(input int w, input int pc, input int sc,
                         input int re_at, input int stop_at);
    int len, base, exp, first, cnt, n;
    string req;
    len = dlen(pc, sc);
    req = (w == 0) ? "R6" : (w == 1) ? "R7" : "R8";
    case (w)
      0: begin lead_pre_i = 2'(pc);  lead_scl_i = 4'(sc);  end
      1: begin trail_pre_i = 2'(pc); trail_scl_i = 4'(sc); end
      default: begin gap_pre_i = 2'(pc); gap_scl_i = 4'(sc); end
    endcase
    base = (re_at > 1) ? re_at : 1;
    exp = (stop_at > 0) ? -1 : base + len;
    n = base + len + 3;
    first = -1; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      dly_start_i = '0;
      dly_start_i[w] = (i == 1) || (i == re_at);
      stop_i = (i == stop_at);
      @(negedge clk_i);
      if (dly_done_o[w]) begin
        cnt++;
        if (first < 0) first = i;
      end
      step();
    end
    dly_start_i = '0; stop_i = 1'b0;
    if (stop_at > 0) begin
      chk(cnt == 0, "R10 no done after stop", cnt, 0);
      chk(!dly_busy_o, "R10 idle after stop", int'(dly_busy_o), 0);
    end else begin
      chk(first == exp, (re_at > 1) ? "R11 restart" : req, first, exp);
      chk(cnt == 1, req, cnt, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    @(negedge clk_i);
    chk(!sck_o && !sck_rise_o && !sck_fall_o, "R4 reset sck", int'(sck_o), 0);
    chk(dly_done_o == 3'b000 && !dly_busy_o, "R6 reset delays", int'(dly_done_o), 0);
    step();

    // directed SCK corners
    run_sck(0, 0, 1'b1, 1'b0);  // P=2
    run_sck(1, 0, 1'b1, 1'b0);  // P=3 odd
    run_sck(3, 2, 1'b1, 1'b0);  // P=21 odd
    run_sck(3, 8, 1'b0, 1'b0);  // large scaler
    run_sck(2, 1, 1'b0, 1'b1);  // freeze
    run_sck(3, 3, 1'b1, 1'b1);  // freeze double rate
    for (int k = 0; k < 40; k++)
      run_sck(int'($urandom_range(3, 0)), int'($urandom_range(5, 0)),
              1'($urandom_range(1, 0)), 1'b0);

    // directed delay corners
    run_dly(0, 0, 0, 0, 0);   // shortest
    run_dly(1, 3, 5, 0, 0);
    run_dly(2, 0, 10, 0, 0);  // long
    run_dly(0, 1, 2, 0, 3);   // stop mid-count
    run_dly(2, 0, 1, 0, 1);   // stop with start
    run_dly(1, 2, 1, 5, 0);   // restart
    for (int k = 0; k < 30; k++)
      run_dly(int'($urandom_range(2, 0)), int'($urandom_range(3, 0)),
              int'($urandom_range(5, 0)), 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule